// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a synchronous 1024 x 8 memory with two fully independent access ports, called left and right, both clocked by one clock. Each port has its own select, output enable, read/write strobe, address, write data, registered read data with a valid flag, a write-block input and an interrupt output. All control inputs and the interrupt outputs are active-low. A read returns data one clock after it is requested. When a port is not driving data, its valid flag is low and its read bus is zero. This stands in for a high-impedance output.

The two highest addresses also serve as a message channel between the two sides. A left-port write to the top word (0x3FF) raises the right interrupt. The right port acknowledges it by reading that word. In the other direction, a right-port write to the word below it (0x3FE) raises the left interrupt, and a left-port read of 0x3FE clears it. Each interrupt flag is a two-state machine with the states MBX_CLEAR and MBX_RAISED. The RAISE transition is taken on a sender write. The ACK transition is taken on a receiver read. If both happen in the same cycle, RAISE wins.

Each port's controls decode to one of five operations:
- PORT_IDLE: the port is deselected.
- PORT_READ: a read that drives data.
- PORT_HIDDEN: a read with the output disabled.
- PORT_WRITE: a write.
- PORT_BLOCKED: a write discarded because the block input is low.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: After reset, both interrupt outputs are high (no message pending) and both valid flags are low.
- R2: With select high, the port performs no access. In the next cycle its valid flag is low and its read bus is zero.
- R3: With select low, the read/write strobe low and the block input high, the write data is stored at the port's address.
- R4: With select low, the strobe high and output enable low, the port shows the stored word on its read bus one cycle later, with the valid flag high. A write to the same address in that same cycle is not seen (read-first).
- R5: With select low, the strobe high and output enable high, the next cycle shows the valid flag low and the read bus zero.
- R6: An unblocked left write to address 0x3FF drives the right interrupt low from the next cycle on.
- R7: A right read of 0x3FF with output enable low sets the right interrupt high in the next cycle. The same read with output enable high leaves it low.
- R8: An unblocked right write to 0x3FE drives the left interrupt low. A left read of 0x3FE with output enable low sets it high again.
- R9: A write on a port whose block input is low changes neither the memory nor any interrupt. Reads on that port are still served.
- R10: The mailbox words 0x3FE and 0x3FF store and return written data like any other location.
- R11: When both ports write the same address in one cycle and neither is blocked, the left port's data is kept.
- R12: When a sender write and a receiver read of the same mailbox fall in one cycle, the interrupt ends up low (pending).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_sel_n | input | 1 | Left select, active-low |
| lp_oe_n | input | 1 | Left output enable, active-low |
| lp_rnw | input | 1 | Left strobe: 1 read, 0 write |
| lp_block_n | input | 1 | Left write block, active-low |
| lp_addr | input | ADDR_W | Left address |
| lp_wdata | input | DATA_W | Left write data |
| lp_rdata | output | DATA_W | Left read data, zero when not valid |
| lp_rvalid | output | 1 | Left read data valid |
| lp_irq_n | output | 1 | Left interrupt, low when a message from the right is pending |
| rp_sel_n | input | 1 | Right select, active-low |
| rp_oe_n | input | 1 | Right output enable, active-low |
| rp_rnw | input | 1 | Right strobe: 1 read, 0 write |
| rp_block_n | input | 1 | Right write block, active-low |
| rp_addr | input | ADDR_W | Right address |
| rp_wdata | input | DATA_W | Right write data |
| rp_rdata | output | DATA_W | Right read data, zero when not valid |
| rp_rvalid | output | 1 | Right read data valid |
| rp_irq_n | output | 1 | Right interrupt, low when a message from the left is pending |

## Verification
The bench builds the block with its default parameters, ADDR_W = 10 and DATA_W = 8. The full 1024-word space is therefore small enough to fill completely in an initial pass, so every later random read has a known expected value. The two mailbox words also sit at the real addresses 0x3FE and 0x3FF. The random phase biases addresses toward the top four words. This makes same-cycle raise/acknowledge pairs, blocked mailbox writes and same-address write collisions occur many times, in addition to the directed cases.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // Decoded operation of one port for the current cycle
    typedef enum logic [2:0] {
        PORT_IDLE,
        PORT_READ,
        PORT_HIDDEN,
        PORT_WRITE,
        PORT_BLOCKED
    } port_op_e;

    // Interrupt flag of one mailbox
    typedef enum logic {
        MBX_CLEAR,
        MBX_RAISED
    } mbx_state_e;

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] SEND_ADDR = '1,
    parameter logic [ADDR_W-1:0] RECV_ADDR = '0
) (
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              rnw,
    input  logic              block_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_en,
    output logic              send_hit,
    output logic              ack_hit
);

    port_op_e op;

    // Operation decode: select, then direction, then enable/block
    always_comb begin
        if (sel_n)
            op = PORT_IDLE;
        else if (!rnw)
            op = block_n ? PORT_WRITE : PORT_BLOCKED;
        else if (oe_n)
            op = PORT_HIDDEN;
        else
            op = PORT_READ;
    end

    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (op)
            PORT_IDLE:    ;
            PORT_READ:    rd_en = 1'b1;
            PORT_HIDDEN:  ;
            PORT_WRITE:   wr_en = 1'b1;
            PORT_BLOCKED: ;
            default:      ;
        endcase
    end

    assign send_hit = wr_en && (addr == SEND_ADDR);
    assign ack_hit  = rd_en && (addr == RECV_ADDR);

endmodule

// File: rtl/dpm_dual_store.sv
module dpm_dual_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Right first, left last: the left write wins on a shared address
    always_ff @(posedge clk) begin
        if (r_wr)
            mem[r_addr] <= r_wdata;
        if (l_wr)
            mem[l_addr] <= l_wdata;
    end

    // Registered reads see the array before this cycle's writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_rdata  <= '0;
            l_rvalid <= 1'b0;
            r_rdata  <= '0;
            r_rvalid <= 1'b0;
        end else begin
            l_rvalid <= l_rd;
            l_rdata  <= l_rd ? mem[l_addr] : '0;
            r_rvalid <= r_rd;
            r_rdata  <= r_rd ? mem[r_addr] : '0;
        end
    end

    AST_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && r_wr && l_addr == r_addr) |=> mem[$past(l_addr)] == $past(l_wdata)); // R11

endmodule

// File: rtl/dpm_mbx_fsm.sv
module dpm_mbx_fsm
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq_n
);

    mbx_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= MBX_CLEAR;
        else
            state <= state_nxt;
    end

    // RAISE has priority over ACK so a fresh message is never lost
    always_comb begin
        state_nxt = state;
        unique case (state)
            MBX_CLEAR:  if (raise) state_nxt = MBX_RAISED;
            MBX_RAISED: if (ack && !raise) state_nxt = MBX_CLEAR;
            default:    state_nxt = MBX_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state)
            MBX_CLEAR:  irq_n = 1'b1;
            MBX_RAISED: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

    AST_MBX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> !irq_n); // R12
    AST_MBX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !raise) |=> irq_n); // R7

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_sel_n,
    input  logic              lp_oe_n,
    input  logic              lp_rnw,
    input  logic              lp_block_n,
    input  logic [ADDR_W-1:0] lp_addr,
    input  logic [DATA_W-1:0] lp_wdata,
    output logic [DATA_W-1:0] lp_rdata,
    output logic              lp_rvalid,
    output logic              lp_irq_n,
    input  logic              rp_sel_n,
    input  logic              rp_oe_n,
    input  logic              rp_rnw,
    input  logic              rp_block_n,
    input  logic [ADDR_W-1:0] rp_addr,
    input  logic [DATA_W-1:0] rp_wdata,
    output logic [DATA_W-1:0] rp_rdata,
    output logic              rp_rvalid,
    output logic              rp_irq_n
);

    // Top word: left-to-right mailbox. Word below: right-to-left mailbox.
    localparam logic [ADDR_W-1:0] L2R_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] R2L_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic l_wr, l_rd, l_send, l_ack;
    logic r_wr, r_rd, r_send, r_ack;

    dpm_port_decode #(
        .ADDR_W(ADDR_W), .SEND_ADDR(L2R_ADDR), .RECV_ADDR(R2L_ADDR)
    ) u_left_dec (
        .sel_n(lp_sel_n), .oe_n(lp_oe_n), .rnw(lp_rnw), .block_n(lp_block_n),
        .addr(lp_addr), .wr_en(l_wr), .rd_en(l_rd),
        .send_hit(l_send), .ack_hit(l_ack)
    );

    dpm_port_decode #(
        .ADDR_W(ADDR_W), .SEND_ADDR(R2L_ADDR), .RECV_ADDR(L2R_ADDR)
    ) u_right_dec (
        .sel_n(rp_sel_n), .oe_n(rp_oe_n), .rnw(rp_rnw), .block_n(rp_block_n),
        .addr(rp_addr), .wr_en(r_wr), .rd_en(r_rd),
        .send_hit(r_send), .ack_hit(r_ack)
    );

    dpm_dual_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .l_wr(l_wr), .l_rd(l_rd), .l_addr(lp_addr), .l_wdata(lp_wdata),
        .l_rdata(lp_rdata), .l_rvalid(lp_rvalid),
        .r_wr(r_wr), .r_rd(r_rd), .r_addr(rp_addr), .r_wdata(rp_wdata),
        .r_rdata(rp_rdata), .r_rvalid(rp_rvalid)
    );

    // Right interrupt: raised by the left, acknowledged by the right
    dpm_mbx_fsm u_to_right (
        .clk(clk), .rst_n(rst_n), .raise(l_send), .ack(r_ack), .irq_n(rp_irq_n)
    );

    // Left interrupt: raised by the right, acknowledged by the left
    dpm_mbx_fsm u_to_left (
        .clk(clk), .rst_n(rst_n), .raise(r_send), .ack(l_ack), .irq_n(lp_irq_n)
    );

    AST_DESEL_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lp_sel_n |=> (!lp_rvalid && lp_rdata == '0)); // R2
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!rp_sel_n && rp_rnw && !rp_oe_n) |=> rp_rvalid); // R4
    AST_HIDDEN_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_sel_n && lp_rnw && lp_oe_n) |=> !lp_rvalid); // R5
    AST_BLOCKED_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_sel_n && !lp_rnw && !lp_block_n && lp_addr == L2R_ADDR && !r_ack)
        |=> $stable(rp_irq_n)); // R9
    AST_L2R_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_sel_n && !lp_rnw && lp_block_n && lp_addr == L2R_ADDR) |=> !rp_irq_n); // R6
    AST_R2L_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rp_sel_n && !rp_rnw && rp_block_n && rp_addr == R2L_ADDR) |=> !lp_irq_n); // R8

endmodule

// File: tb/dpm_mailbox_ram_bench.sv
module dpm_mailbox_ram_bench;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOPA = 10'h3FF;
    localparam logic [AW-1:0] NXTA = 10'h3FE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lsel = 1, loe = 1, lrnw = 1, lblk = 1;
    logic rsel = 1, roe = 1, rrnw = 1, rblk = 1;
    logic [AW-1:0] laddr = '0, raddr = '0;
    logic [DW-1:0] lwd = '0, rwd = '0;
    logic [DW-1:0] lrd, rrd;
    logic lrv, rrv, lirq, rirq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic flag_r = 0, flag_l = 0;
    logic [DW-1:0] exp_lrd, exp_rrd;
    logic exp_lrv, exp_rrv;

    always #2 clk = ~clk;

    dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dpm_mailbox_ram (
        .clk(clk), .rst_n(rst_n),
        .lp_sel_n(lsel), .lp_oe_n(loe), .lp_rnw(lrnw), .lp_block_n(lblk),
        .lp_addr(laddr), .lp_wdata(lwd), .lp_rdata(lrd), .lp_rvalid(lrv),
        .lp_irq_n(lirq),
        .rp_sel_n(rsel), .rp_oe_n(roe), .rp_rnw(rrnw), .rp_block_n(rblk),
        .rp_addr(raddr), .rp_wdata(rwd), .rp_rdata(rrd), .rp_rvalid(rrv),
        .rp_irq_n(rirq)
    );

    function automatic logic mbx_next(logic f, logic set, logic clr);
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return f;
    endfunction

    function automatic string rd_tag(logic sel_n, logic rnw, logic oe_n);
        if (sel_n) return "R2";
        if (rnw && oe_n) return "R5";
        if (rnw) return "R4";
        return "R3";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock with the current inputs; model predicted, outputs compared
    task automatic step();
        logic lw, rw, lr, rr;
        string lt, rt;
        lw = !lsel && !lrnw && lblk;
        rw = !rsel && !rrnw && rblk;
        lr = !lsel && lrnw && !loe;
        rr = !rsel && rrnw && !roe;
        lt = rd_tag(lsel, lrnw, loe);
        rt = rd_tag(rsel, rrnw, roe);
        exp_lrv = lr;
        exp_rrv = rr;
        exp_lrd = lr ? ref_mem[laddr] : '0;
        exp_rrd = rr ? ref_mem[raddr] : '0;
        flag_r = mbx_next(flag_r, lw && laddr == TOPA, rr && raddr == TOPA);
        flag_l = mbx_next(flag_l, rw && raddr == NXTA, lr && laddr == NXTA);
        if (rw) ref_mem[raddr] = rwd;
        if (lw) ref_mem[laddr] = lwd;
        @(posedge clk);
        #1;
        chk(lt, {31'd0, lrv}, {31'd0, exp_lrv});
        chk(lt, {24'd0, lrd}, {24'd0, exp_lrd});
        chk(rt, {31'd0, rrv}, {31'd0, exp_rrv});
        chk(rt, {24'd0, rrd}, {24'd0, exp_rrd});
        chk(flag_r ? "R6" : "R7", {31'd0, rirq}, {31'd0, !flag_r});
        chk("R8", {31'd0, lirq}, {31'd0, !flag_l});
    endtask

    task automatic idle_all();
        lsel = 1; loe = 1; lrnw = 1; lblk = 1;
        rsel = 1; roe = 1; rrnw = 1; rblk = 1;
    endtask

    task automatic lset(logic s, logic o, logic w, logic b, logic [AW-1:0] a, logic [DW-1:0] d);
        lsel = s; loe = o; lrnw = w; lblk = b; laddr = a; lwd = d;
    endtask

    task automatic rset(logic s, logic o, logic w, logic b, logic [AW-1:0] a, logic [DW-1:0] d);
        rsel = s; roe = o; rrnw = w; rblk = b; raddr = a; rwd = d;
    endtask

    function automatic logic [AW-1:0] pick_addr();
        if ($urandom % 3 == 0) return TOPA - AW'($urandom % 4);
        if ($urandom % 4 == 0) return AW'($urandom % 8);
        return AW'($urandom);
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        idle_all();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", {31'd0, lirq}, 32'd1);
        chk("R1", {31'd0, rirq}, 32'd1);
        chk("R1", {31'd0, lrv}, 32'd0);
        chk("R1", {31'd0, rrv}, 32'd0);
        rst_n = 1'b1;

        // R3: fill the whole array from the left port
        for (int a = 0; a < DEPTH; a++) begin
            lset(0, 1, 0, 1, AW'(a), DW'(a) ^ 8'hA5);
            step();
        end
        idle_all();
        step();
        chk("R6", {31'd0, rirq}, 32'd0);

        // R7: output-disabled read leaves the flag, enabled read clears it
        rset(0, 1, 1, 1, TOPA, 0);
        step();
        chk("R7", {31'd0, rirq}, 32'd0);
        rset(0, 0, 1, 1, TOPA, 0);
        step();
        chk("R7", {31'd0, rirq}, 32'd1);
        chk("R10", {24'd0, rrd}, {24'd0, 8'hFF ^ 8'hA5});

        // R8 and R10: right to left message
        idle_all();
        rset(0, 1, 0, 1, NXTA, 8'h3C);
        step();
        chk("R8", {31'd0, lirq}, 32'd0);
        idle_all();
        lset(0, 0, 1, 1, NXTA, 0);
        step();
        chk("R8", {31'd0, lirq}, 32'd1);
        chk("R10", {24'd0, lrd}, 32'h3C);

        // R9: blocked mailbox write changes neither flag nor data
        idle_all();
        lset(0, 1, 0, 0, TOPA, 8'h77);
        step();
        chk("R9", {31'd0, rirq}, 32'd1);
        lset(0, 0, 1, 0, TOPA, 0);
        step();
        chk("R9", {24'd0, lrd}, {24'd0, 8'hFF ^ 8'hA5});
        chk("R9", {31'd0, lrv}, 32'd1);

        // R11: same-address write collision
        idle_all();
        lset(0, 1, 0, 1, 10'h010, 8'h11);
        rset(0, 1, 0, 1, 10'h010, 8'h22);
        step();
        idle_all();
        rset(0, 0, 1, 1, 10'h010, 0);
        step();
        chk("R11", {24'd0, rrd}, 32'h11);

        // R4: read-first against a same-cycle write from the other port
        idle_all();
        lset(0, 0, 1, 1, 10'h020, 0);
        rset(0, 1, 0, 1, 10'h020, 8'hC3);
        step();
        chk("R4", {24'd0, lrd}, {24'd0, 8'h20 ^ 8'hA5});

        // R12: send and acknowledge in one cycle
        idle_all();
        lset(0, 1, 0, 1, TOPA, 8'h5E);
        rset(0, 0, 1, 1, TOPA, 0);
        step();
        chk("R12", {31'd0, rirq}, 32'd0);
        idle_all();
        rset(0, 0, 1, 1, TOPA, 0);
        step();
        chk("R12", {31'd0, rirq}, 32'd1);

        // R2: deselected port shows nothing
        idle_all();
        lset(1, 0, 1, 1, 10'h005, 0);
        step();
        chk("R2", {31'd0, lrv}, 32'd0);
        chk("R2", {24'd0, lrd}, 32'd0);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            lset(($urandom % 5) == 0, ($urandom % 5) == 0, $urandom % 2,
                 ($urandom % 7) != 0, pick_addr(), DW'($urandom));
            rset(($urandom % 5) == 0, ($urandom % 5) == 0, $urandom % 2,
                 ($urandom % 7) != 0, pick_addr(), DW'($urandom));
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule